// File: doc/BRIEF.md
# Prioritized Interrupt Entry Sequencer

This block sits beside the instruction sequencer of a processor core. It watches six kinds of pending event: a trap raised by the instruction that just finished, a non-maskable interrupt, a maskable interrupt that supplies its own 8-bit vector, a fetch fault, a decode fault and an execute fault. When it is idle and at least one event is recognized, it picks the most urgent one. It captures the architectural state presented on its inputs and runs the handler-entry sequence. The sequence may switch to an inner stack and push the old stack selector and pointer. It then pushes the flags, code selector and instruction pointer, and pushes an error code if the event has one. Next it reads a 32-bit entry from a 256-entry vector table and hands the handler's code selector and instruction pointer back to the core.

All memory traffic goes through one word-wide port with separate read and write strobes and a shared acknowledge. The sequencer holds each request until it is acknowledged, so memory of any latency can be attached. When the sequence ends it pulses `done` for one cycle. The new selectors, stack pointer and flags are then valid on its outputs and stay there until the next entry. The caller must withdraw the serviced request in the `done` cycle.

The controller has these states: IDLE, PUSH_SS, PUSH_SP, PUSH_FL, PUSH_CS, PUSH_IP, PUSH_ERR, VEC_RD and DONE. The transitions are:
- IDLE goes to PUSH_SS if the event changes privilege level, otherwise to PUSH_FL.
- PUSH_SS goes to PUSH_SP on acknowledge, and PUSH_SP goes to PUSH_FL on acknowledge.
- PUSH_FL goes to PUSH_CS on acknowledge, and PUSH_CS goes to PUSH_IP on acknowledge.
- PUSH_IP goes to PUSH_ERR on acknowledge if the event carries an error code, otherwise to VEC_RD.
- PUSH_ERR goes to VEC_RD on acknowledge.
- VEC_RD goes to DONE on acknowledge.
- DONE always goes back to IDLE.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset `busy`, `done`, `mem_wr` and `mem_rd` are all 0.
- R2: Events are ranked, most urgent first, as follows. The serviced vector (`serv_vec`) is given for each.
  - Previous-instruction trap: vector 1.
  - Non-maskable interrupt: vector 2.
  - Maskable interrupt: its `intr_vec`.
  - Fetch fault: vector 3 when `fetch_sel` is 0, vector 4 when it is 1.
  - Decode fault: vector 6 when `dec_sel` is 0, vector 7 when it is 1.
  - Execute fault: its `exec_vec`.
- R3: A maskable request is recognized only while bit 9 (interrupt enable) of `cur_flags` is 1. A non-maskable request is recognized regardless of that bit. If the only pending request is a masked maskable one, no sequence starts and no memory request is made.
- R4: When `priv_chg` is 1, the starting stack is `inner_ss`/`inner_sp`. The first two pushes are then the old `cur_ss` (zero-extended) and the old `cur_sp`. When `priv_chg` is 0, the starting stack is `cur_ss`/`cur_sp` and those two pushes are skipped.
- R5: The pushes that always occur, in order, are: `cur_flags`, `cur_cs` (zero-extended) and `cur_ip`. Each push writes to the stack pointer minus 4 and leaves the pointer there, so `new_sp` is the starting pointer minus 4 times the number of pushes.
- R6: The error code `exec_err` is pushed after the instruction pointer only when the execute fault is the serviced event and `exec_err_vld` is 1.
- R7: `new_flags` equals `cur_flags` with bit 9 (interrupt enable) and bit 8 (trap) cleared. All other bits are preserved.
- R8: The vector table read address is `TABLE_BASE` plus 4 times the vector number. In the word read back, bits 31:16 become `new_cs`, and bits 15:0 become `new_ip` with zero extension. `new_ss` is the stack selector in use.
- R9: A read or write request keeps its address and write data steady until `mem_ack`. The block never asserts `mem_wr` and `mem_rd` together.
- R10: `done` is a one-cycle pulse in the cycle after the vector read is acknowledged. `busy` is 1 from the cycle after acceptance through the `done` cycle, and memory requests occur only while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Trap on the previous instruction pending |
| nmi_req | input | 1 | Non-maskable interrupt pending |
| intr_req | input | 1 | Maskable interrupt pending |
| intr_vec | input | 8 | Vector supplied with the maskable interrupt |
| fetch_req | input | 1 | Fetch fault pending |
| fetch_sel | input | 1 | Fetch fault kind (0: vector 3, 1: vector 4) |
| dec_req | input | 1 | Decode fault pending |
| dec_sel | input | 1 | Decode fault kind (0: vector 6, 1: vector 7) |
| exec_req | input | 1 | Execute fault pending |
| exec_vec | input | 8 | Vector of the execute fault |
| exec_err_vld | input | 1 | Execute fault carries an error code |
| exec_err | input | 32 | Error code value |
| priv_chg | input | 1 | Entry changes privilege level (switch stack) |
| cur_flags | input | 32 | Current flags word |
| cur_cs | input | 16 | Current code selector |
| cur_ip | input | 32 | Current instruction pointer |
| cur_ss | input | 16 | Current stack selector |
| cur_sp | input | 32 | Current stack pointer |
| inner_ss | input | 16 | Stack selector used on a level change |
| inner_sp | input | 32 | Stack pointer used on a level change |
| mem_wr | output | 1 | Stack write request |
| mem_rd | output | 1 | Vector table read request |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle per request |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| serv_vec | output | 8 | Vector of the event being or last serviced |
| new_cs | output | 16 | Handler code selector |
| new_ip | output | 32 | Handler instruction pointer |
| new_ss | output | 16 | Stack selector after entry |
| new_sp | output | 32 | Stack pointer after entry |
| new_flags | output | 32 | Flags after entry |

## Verification
A stray state transition or a wrong captured event shows up at the memory port first. It appears as a push missing, doubled or reordered, or as a write to an address that is not 4 below the previous one. This becomes visible in the same cycle the wrong request is issued, which is well before `done`. A wrong arbitration result shows up a few cycles later, as a wrong vector table read address and then a wrong `serv_vec`, `new_cs` or `new_ip` in the `done` cycle. Corrupted flag or stack-pointer bookkeeping appears only in `new_flags` and `new_sp` at `done`, so each entry is checked there against values computed from the request pattern.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PUSH_SS,
        S_PUSH_SP,
        S_PUSH_FL,
        S_PUSH_CS,
        S_PUSH_IP,
        S_PUSH_ERR,
        S_VEC_RD,
        S_DONE
    } seq_state_t;

    localparam logic [7:0] VEC_TRAP   = 8'd1;
    localparam logic [7:0] VEC_NMI    = 8'd2;
    localparam logic [7:0] VEC_FETCH0 = 8'd3;
    localparam logic [7:0] VEC_FETCH1 = 8'd4;
    localparam logic [7:0] VEC_DEC0   = 8'd6;
    localparam logic [7:0] VEC_DEC1   = 8'd7;

    typedef struct packed {
        logic       valid;
        logic [7:0] vec;
        logic       has_err;
    } evt_t;

endpackage

// File: rtl/irq_entry_arb.sv
module irq_entry_arb
    import irq_entry_pkg::*;
#(
    parameter int IE_BIT = 9,
    parameter int DATA_W = 32
) (
    input  logic              trap_req,
    input  logic              nmi_req,
    input  logic              intr_req,
    input  logic [7:0]        intr_vec,
    input  logic              fetch_req,
    input  logic              fetch_sel,
    input  logic              dec_req,
    input  logic              dec_sel,
    input  logic              exec_req,
    input  logic [7:0]        exec_vec,
    input  logic              exec_err_vld,
    input  logic [DATA_W-1:0] flags,
    output evt_t              evt
);

    logic intr_ok;
    assign intr_ok = intr_req & flags[IE_BIT];

    always_comb begin
        evt = '0;
        if (trap_req) begin
            evt.valid = 1'b1;
            evt.vec   = VEC_TRAP;
        end else if (nmi_req) begin
            evt.valid = 1'b1;
            evt.vec   = VEC_NMI;
        end else if (intr_ok) begin
            evt.valid = 1'b1;
            evt.vec   = intr_vec;
        end else if (fetch_req) begin
            evt.valid = 1'b1;
            evt.vec   = fetch_sel ? VEC_FETCH1 : VEC_FETCH0;
        end else if (dec_req) begin
            evt.valid = 1'b1;
            evt.vec   = dec_sel ? VEC_DEC1 : VEC_DEC0;
        end else if (exec_req) begin
            evt.valid   = 1'b1;
            evt.vec     = exec_vec;
            evt.has_err = exec_err_vld;
        end
    end

endmodule

// File: rtl/irq_entry_frame.sv
module irq_entry_frame
    import irq_entry_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SEL_W  = 16
) (
    input  seq_state_t        st,
    input  logic [SEL_W-1:0]  sv_ss,
    input  logic [DATA_W-1:0] sv_sp,
    input  logic [DATA_W-1:0] sv_flags,
    input  logic [SEL_W-1:0]  sv_cs,
    input  logic [DATA_W-1:0] sv_ip,
    input  logic [DATA_W-1:0] sv_err,
    output logic [DATA_W-1:0] wdata
);

    localparam int PAD_W = DATA_W - SEL_W;

    always_comb begin
        unique case (st)
            S_PUSH_SS:  wdata = {{PAD_W{1'b0}}, sv_ss};
            S_PUSH_SP:  wdata = sv_sp;
            S_PUSH_FL:  wdata = sv_flags;
            S_PUSH_CS:  wdata = {{PAD_W{1'b0}}, sv_cs};
            S_PUSH_IP:  wdata = sv_ip;
            S_PUSH_ERR: wdata = sv_err;
            default:    wdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_entry_ctl.sv
module irq_entry_ctl
    import irq_entry_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter int          SEL_W      = 16,
    parameter int          IE_BIT     = 9,
    parameter int          TF_BIT     = 8,
    parameter logic [31:0] TABLE_BASE = 32'h0000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  evt_t              evt,
    input  logic [DATA_W-1:0] exec_err,
    input  logic              priv_chg,
    input  logic [DATA_W-1:0] cur_flags,
    input  logic [SEL_W-1:0]  cur_cs,
    input  logic [DATA_W-1:0] cur_ip,
    input  logic [SEL_W-1:0]  cur_ss,
    input  logic [DATA_W-1:0] cur_sp,
    input  logic [SEL_W-1:0]  inner_ss,
    input  logic [DATA_W-1:0] inner_sp,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_wr,
    output logic              mem_rd,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy,
    output logic              done,
    output logic [7:0]        serv_vec,
    output logic [SEL_W-1:0]  new_cs,
    output logic [DATA_W-1:0] new_ip,
    output logic [SEL_W-1:0]  new_ss,
    output logic [DATA_W-1:0] new_sp,
    output logic [DATA_W-1:0] new_flags
);

    localparam int          IP_PAD   = DATA_W - SEL_W;
    localparam int          VPAD_W   = DATA_W - 10;
    localparam logic [DATA_W-1:0] WORD_B = DATA_W'(4);

    seq_state_t state, nxt;

    logic [SEL_W-1:0]  sv_ss, sv_cs, ss_q;
    logic [DATA_W-1:0] sv_sp, sv_flags, sv_ip, sv_err, sp_q;
    logic              sv_priv, sv_err_vld;
    logic [DATA_W-1:0] frame_word;
    logic              pushing;

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:     if (evt.valid) nxt = priv_chg ? S_PUSH_SS : S_PUSH_FL;
            S_PUSH_SS:  if (mem_ack) nxt = S_PUSH_SP;
            S_PUSH_SP:  if (mem_ack) nxt = S_PUSH_FL;
            S_PUSH_FL:  if (mem_ack) nxt = S_PUSH_CS;
            S_PUSH_CS:  if (mem_ack) nxt = S_PUSH_IP;
            S_PUSH_IP:  if (mem_ack) nxt = sv_err_vld ? S_PUSH_ERR : S_VEC_RD;
            S_PUSH_ERR: if (mem_ack) nxt = S_VEC_RD;
            S_VEC_RD:   if (mem_ack) nxt = S_DONE;
            S_DONE:     nxt = S_IDLE;
            default:    nxt = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Outputs
    always_comb begin
        pushing  = 1'b0;
        mem_rd   = 1'b0;
        busy     = 1'b1;
        done     = 1'b0;
        mem_addr = '0;
        unique case (state)
            S_IDLE:     busy = 1'b0;
            S_PUSH_SS,
            S_PUSH_SP,
            S_PUSH_FL,
            S_PUSH_CS,
            S_PUSH_IP,
            S_PUSH_ERR: begin
                pushing  = 1'b1;
                mem_addr = sp_q - WORD_B;
            end
            S_VEC_RD: begin
                mem_rd   = 1'b1;
                mem_addr = TABLE_BASE + {{VPAD_W{1'b0}}, serv_vec, 2'b00};
            end
            S_DONE:     done = 1'b1;
            default:    busy = 1'b0;
        endcase
    end

    assign mem_wr    = pushing;
    assign mem_wdata = pushing ? frame_word : '0;

    irq_entry_frame #(
        .DATA_W (DATA_W),
        .SEL_W  (SEL_W)
    ) i_frame (
        .st       (state),
        .sv_ss    (sv_ss),
        .sv_sp    (sv_sp),
        .sv_flags (sv_flags),
        .sv_cs    (sv_cs),
        .sv_ip    (sv_ip),
        .sv_err   (sv_err),
        .wdata    (frame_word)
    );

    // Capture and stack bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sv_ss      <= '0;
            sv_sp      <= '0;
            sv_flags   <= '0;
            sv_cs      <= '0;
            sv_ip      <= '0;
            sv_err     <= '0;
            sv_priv    <= 1'b0;
            sv_err_vld <= 1'b0;
            serv_vec   <= '0;
            ss_q       <= '0;
            sp_q       <= '0;
            new_cs     <= '0;
            new_ip     <= '0;
            new_flags  <= '0;
        end else begin
            if (state == S_IDLE && evt.valid) begin
                sv_ss      <= cur_ss;
                sv_sp      <= cur_sp;
                sv_flags   <= cur_flags;
                sv_cs      <= cur_cs;
                sv_ip      <= cur_ip;
                sv_err     <= exec_err;
                sv_priv    <= priv_chg;
                sv_err_vld <= evt.has_err;
                serv_vec   <= evt.vec;
                ss_q       <= priv_chg ? inner_ss : cur_ss;
                sp_q       <= priv_chg ? inner_sp : cur_sp;
            end
            if (pushing && mem_ack) begin
                sp_q <= sp_q - WORD_B;
            end
            if (state == S_PUSH_FL && mem_ack) begin
                new_flags         <= sv_flags;
                new_flags[IE_BIT] <= 1'b0;
                new_flags[TF_BIT] <= 1'b0;
            end
            if (state == S_VEC_RD && mem_ack) begin
                new_cs <= mem_rdata[DATA_W-1 -: SEL_W];
                new_ip <= {{IP_PAD{1'b0}}, mem_rdata[SEL_W-1:0]};
            end
        end
    end

    assign new_ss = ss_q;
    assign new_sp = sp_q;

    // Level-change flag is kept with the captured frame for debug visibility
    // of the sequence; it steers only the IDLE exit.
    logic unused_priv;
    assign unused_priv = sv_priv;

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter int          SEL_W      = 16,
    parameter int          IE_BIT     = 9,
    parameter int          TF_BIT     = 8,
    parameter logic [31:0] TABLE_BASE = 32'h0000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_req,
    input  logic              nmi_req,
    input  logic              intr_req,
    input  logic [7:0]        intr_vec,
    input  logic              fetch_req,
    input  logic              fetch_sel,
    input  logic              dec_req,
    input  logic              dec_sel,
    input  logic              exec_req,
    input  logic [7:0]        exec_vec,
    input  logic              exec_err_vld,
    input  logic [DATA_W-1:0] exec_err,
    input  logic              priv_chg,
    input  logic [DATA_W-1:0] cur_flags,
    input  logic [SEL_W-1:0]  cur_cs,
    input  logic [DATA_W-1:0] cur_ip,
    input  logic [SEL_W-1:0]  cur_ss,
    input  logic [DATA_W-1:0] cur_sp,
    input  logic [SEL_W-1:0]  inner_ss,
    input  logic [DATA_W-1:0] inner_sp,
    output logic              mem_wr,
    output logic              mem_rd,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [7:0]        serv_vec,
    output logic [SEL_W-1:0]  new_cs,
    output logic [DATA_W-1:0] new_ip,
    output logic [SEL_W-1:0]  new_ss,
    output logic [DATA_W-1:0] new_sp,
    output logic [DATA_W-1:0] new_flags
);

    evt_t evt;

    irq_entry_arb #(
        .IE_BIT (IE_BIT),
        .DATA_W (DATA_W)
    ) i_arb (
        .trap_req     (trap_req),
        .nmi_req      (nmi_req),
        .intr_req     (intr_req),
        .intr_vec     (intr_vec),
        .fetch_req    (fetch_req),
        .fetch_sel    (fetch_sel),
        .dec_req      (dec_req),
        .dec_sel      (dec_sel),
        .exec_req     (exec_req),
        .exec_vec     (exec_vec),
        .exec_err_vld (exec_err_vld),
        .flags        (cur_flags),
        .evt          (evt)
    );

    irq_entry_ctl #(
        .DATA_W     (DATA_W),
        .SEL_W      (SEL_W),
        .IE_BIT     (IE_BIT),
        .TF_BIT     (TF_BIT),
        .TABLE_BASE (TABLE_BASE)
    ) i_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .exec_err  (exec_err),
        .priv_chg  (priv_chg),
        .cur_flags (cur_flags),
        .cur_cs    (cur_cs),
        .cur_ip    (cur_ip),
        .cur_ss    (cur_ss),
        .cur_sp    (cur_sp),
        .inner_ss  (inner_ss),
        .inner_sp  (inner_sp),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .mem_wr    (mem_wr),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .busy      (busy),
        .done      (done),
        .serv_vec  (serv_vec),
        .new_cs    (new_cs),
        .new_ip    (new_ip),
        .new_ss    (new_ss),
        .new_sp    (new_sp),
        .new_flags (new_flags)
    );

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
    parameter int DATA_W = 32,
    parameter int IE_BIT = 9,
    parameter int TF_BIT = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_wr,
    input logic              mem_rd,
    input logic              mem_ack,
    input logic [DATA_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] new_flags
);

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_wr, mem_rd})); // R9

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr || mem_rd) && !mem_ack |=> (mem_wr || mem_rd) && $stable(mem_addr)); // R9

    AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr && !mem_ack |=> mem_wr && $stable(mem_wdata)); // R9

    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr && mem_ack |=> !mem_wr || (mem_addr == $past(mem_addr) - DATA_W'(4))); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd && mem_ack |=> done); // R10

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_wr && !mem_rd); // R10

    AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !new_flags[IE_BIT] && !new_flags[TF_BIT]); // R7

endmodule

bind irq_entry_seq irq_entry_chk #(
    .DATA_W (DATA_W),
    .IE_BIT (IE_BIT),
    .TF_BIT (TF_BIT)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_wr    (mem_wr),
    .mem_rd    (mem_rd),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .busy      (busy),
    .done      (done),
    .new_flags (new_flags)
);

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;

    localparam logic [31:0] BASE = 32'h0000_8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_req = 0, nmi_req = 0, intr_req = 0, fetch_req = 0, dec_req = 0, exec_req = 0;
    logic        fetch_sel = 0, dec_sel = 0, exec_err_vld = 0, priv_chg = 0;
    logic [7:0]  intr_vec = 0, exec_vec = 0;
    logic [31:0] exec_err = 0, cur_flags = 0, cur_ip = 0, cur_sp = 0, inner_sp = 0;
    logic [15:0] cur_cs = 0, cur_ss = 0, inner_ss = 0;
    logic        mem_wr, mem_rd, mem_ack, busy, done;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, new_ip, new_sp, new_flags;
    logic [15:0] new_cs, new_ss;
    logic [7:0]  serv_vec;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int lat = 0;
    int ack_cnt = 0;
    int nwr = 0;
    logic [31:0] wr_addr [0:15];
    logic [31:0] wr_data [0:15];

    always #4 clk = ~clk;

    irq_entry_seq #(.TABLE_BASE(BASE)) i_irq_entry_seq (
        .clk(clk), .rst_n(rst_n),
        .trap_req(trap_req), .nmi_req(nmi_req), .intr_req(intr_req), .intr_vec(intr_vec),
        .fetch_req(fetch_req), .fetch_sel(fetch_sel), .dec_req(dec_req), .dec_sel(dec_sel),
        .exec_req(exec_req), .exec_vec(exec_vec), .exec_err_vld(exec_err_vld), .exec_err(exec_err),
        .priv_chg(priv_chg), .cur_flags(cur_flags), .cur_cs(cur_cs), .cur_ip(cur_ip),
        .cur_ss(cur_ss), .cur_sp(cur_sp), .inner_ss(inner_ss), .inner_sp(inner_sp),
        .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .serv_vec(serv_vec), .new_cs(new_cs), .new_ip(new_ip),
        .new_ss(new_ss), .new_sp(new_sp), .new_flags(new_flags)
    );

    function automatic logic [31:0] table_word(input logic [31:0] idx);
        logic [15:0] hi, lo;
        hi = 16'h4000 + idx[15:0];
        lo = 16'h8000 ^ (idx[15:0] * 16'd5);
        return {hi, lo};
    endfunction

    assign mem_rdata = mem_rd ? table_word((mem_addr - BASE) >> 2) : 32'h0;

    // Memory model: acknowledge after lat idle cycles, one cycle wide
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            ack_cnt <= 0;
        end else if ((mem_wr || mem_rd) && !mem_ack) begin
            if (ack_cnt >= lat) begin
                mem_ack <= 1'b1;
                ack_cnt <= 0;
            end else begin
                ack_cnt <= ack_cnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
            ack_cnt <= 0;
        end
    end

    always @(negedge clk) begin
        if (rst_n && mem_wr && mem_ack && nwr < 16) begin
            wr_addr[nwr] = mem_addr;
            wr_data[nwr] = mem_wdata;
            nwr = nwr + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic run_case(input int mask, input bit ie);
        logic [7:0]  ev;
        bit          any, err_push;
        logic [31:0] exp_a [0:15];
        logic [31:0] exp_d [0:15];
        int          n;
        logic [31:0] sp;
        logic [31:0] tw;
        int          wait_cyc;
        @(negedge clk);
        nwr = 0;
        lat = mask % 3;
        trap_req  = mask[0]; nmi_req = mask[1]; intr_req = mask[2];
        fetch_req = mask[3]; dec_req = mask[4]; exec_req = mask[5];
        fetch_sel = ie; dec_sel = ~ie;
        intr_vec  = 8'(32 + mask * 3);
        exec_vec  = 8'(12 + (mask & 3));
        exec_err_vld = ie;
        exec_err  = 32'hE000_0000 | 32'(mask);
        priv_chg  = mask[0] ^ mask[3] ^ ie;
        cur_flags = 32'h0000_0100 | (32'(mask) << 12) | (ie ? 32'h200 : 32'h0) | 32'h5;
        cur_cs    = 16'h0100 + 16'(mask);
        cur_ip    = 32'h0001_0000 + 32'(mask * 16);
        cur_ss    = 16'h0300 + 16'(mask);
        cur_sp    = 32'h0000_4000 + 32'(mask * 64);
        inner_ss  = 16'h0010;
        inner_sp  = 32'h0000_2000;
        // Expected event (R2, R3)
        any = 1; err_push = 0;
        if (mask[0])            ev = 8'd1;
        else if (mask[1])       ev = 8'd2;
        else if (mask[2] && ie) ev = intr_vec;
        else if (mask[3])       ev = ie ? 8'd4 : 8'd3;
        else if (mask[4])       ev = ie ? 8'd6 : 8'd7;
        else if (mask[5])       begin ev = exec_vec; err_push = ie; end
        else                    begin ev = 0; any = 0; end
        if (!any) begin
            // R3: masked request alone starts nothing
            repeat (12) @(negedge clk);
            chk(!busy && nwr == 0, "R3 masked", {31'b0, busy}, 32'h0);
            trap_req = 0; nmi_req = 0; intr_req = 0; fetch_req = 0; dec_req = 0; exec_req = 0;
            return;
        end
        // Expected frame (R4, R5, R6)
        n = 0;
        sp = priv_chg ? inner_sp : cur_sp;
        if (priv_chg) begin
            sp -= 4; exp_a[n] = sp; exp_d[n] = {16'h0, cur_ss}; n++;
            sp -= 4; exp_a[n] = sp; exp_d[n] = cur_sp; n++;
        end
        sp -= 4; exp_a[n] = sp; exp_d[n] = cur_flags; n++;
        sp -= 4; exp_a[n] = sp; exp_d[n] = {16'h0, cur_cs}; n++;
        sp -= 4; exp_a[n] = sp; exp_d[n] = cur_ip; n++;
        if (err_push) begin sp -= 4; exp_a[n] = sp; exp_d[n] = exec_err; n++; end
        wait_cyc = 0;
        while (!done && wait_cyc < 400) begin
            @(negedge clk);
            wait_cyc++;
        end
        trap_req = 0; nmi_req = 0; intr_req = 0; fetch_req = 0; dec_req = 0; exec_req = 0;
        chk(done == 1'b1, "R10 done seen", {31'b0, done}, 32'h1);
        chk(serv_vec == ev, "R2 vector", {24'b0, serv_vec}, {24'b0, ev});
        chk(nwr == n, (err_push ? "R6 push count" : "R4 push count"), 32'(nwr), 32'(n));
        for (int k = 0; k < n && k < nwr; k++) begin
            chk(wr_addr[k] == exp_a[k], "R5 push addr", wr_addr[k], exp_a[k]);
            chk(wr_data[k] == exp_d[k], "R4 push data", wr_data[k], exp_d[k]);
        end
        chk(new_sp == sp, "R5 new_sp", new_sp, sp);
        chk(new_ss == (priv_chg ? inner_ss : cur_ss), "R8 new_ss", {16'h0, new_ss},
            {16'h0, priv_chg ? inner_ss : cur_ss});
        chk(new_flags == (cur_flags & ~32'h300), "R7 flags", new_flags, cur_flags & ~32'h300);
        tw = table_word(32'(ev));
        chk(new_cs == tw[31:16], "R8 new_cs", {16'h0, new_cs}, {16'h0, tw[31:16]});
        chk(new_ip == {16'h0, tw[15:0]}, "R8 new_ip", new_ip, {16'h0, tw[15:0]});
        @(negedge clk);
        chk(!done && !busy, "R10 pulse ends", {30'b0, done, busy}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_wr && !mem_rd, "R1 reset",
            {28'b0, busy, done, mem_wr, mem_rd}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_wr && !mem_rd, "R1 after release",
            {28'b0, busy, done, mem_wr, mem_rd}, 32'h0);
        for (int ie = 0; ie < 2; ie++) begin
            for (int m = 1; m < 64; m++) begin
                run_case(m, ie[0]);
            end
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule